// File: doc/BRIEF.md
# Flow-Controlled Serial Character Transmitter

This block turns a stream of bytes into asynchronous serial characters on one output line. Each byte arrives over a valid/ready handshake. It goes out as a frame of ten bit periods: a low start bit, the eight data bits with the least significant bit first, and a high stop bit. Bit timing comes from an external single-cycle `baud_tick` pulse, one per bit period. The line changes only in the clock cycle after a tick, and back-to-back bytes leave with no gap between frames.

When `flow_en` is set, the clear-to-send input `cts` (1 = clear) can halt the transmitter, but only between characters. Bit position k of a frame counts from 0 for the start bit up to 9 for the stop bit. During a data character, `cts` is sampled at each tick. A low sample taken while bit position 0 to 5 is on the line stops the transmitter after the current character. A first low sample at positions 6 to 9 lets one more character start. That next character then normally picks up the negation in its own early half and stops after itself.

While halted, the engine sends whole idle characters: ten bit periods at logic one. At the end of each idle character it checks `cts` again. Once `cts` is high, it resumes with the pending byte, without reporting any error. A separate detector watches the receive line `rx_line` at each tick and raises `rx_idle` once the line has stayed high for a full character time.

The engine has three states:
- **WAIT**: line high, no character in progress.
- **SEND**: a data character is being shifted out.
- **HOLD**: an idle character is being sent while halted.

Its transitions are:
- **launch**: WAIT→SEND, on a tick with a byte valid and the line clear.
- **chain**: SEND→SEND, at the frame end with the next byte valid and no halt.
- **finish**: SEND→WAIT, at the frame end with no byte pending.
- **park**: SEND→HOLD, at the frame end after an early negation.
- **repeat**: HOLD→HOLD, at the idle-frame end while `cts` is still low.
- **resume**: HOLD→SEND, at the idle-frame end with `cts` high and a byte valid.
- **release**: HOLD→WAIT, at the idle-frame end with `cts` high and nothing pending.

Top module: `async_flow_tx`

## Requirements
- R1: Every character occupies ten bit periods: bit position 0 is the start bit (0), positions 1 to 8 carry data bits 0 to 7 (LSB first), and position 9 is the stop bit (1). `tx_line` changes only in the cycle after a clock edge at which `baud_tick` was high.
- R2: After reset, and while no character is in progress, `tx_line` is 1.
- R3: A byte is taken only in a cycle where `s_valid`, `s_ready` and `baud_tick` are all high. Its start bit appears on the line in the next cycle. While `s_valid` stays high, successive frames start exactly ten bit periods apart.
- R4: With `flow_en` low, `cts` has no effect: every byte goes out back to back, even with `cts` held low.
- R5: With `flow_en` high, a low `cts` sampled at a tick while positions 0 to 5 of a data character are on the line lets that character finish, and no further data character starts while `cts` stays low.
- R6: With `flow_en` high, when the first low `cts` sample of a data character falls at positions 6 to 9, exactly one more data character is sent before the halt (with `cts` held low).
- R7: While halted, `tx_line` stays 1 and no byte is accepted.
- R8: After `cts` returns high, transmission resumes at the next idle-character boundary. All pending bytes then go out in order, none lost or repeated.
- R9: `rx_idle` goes to 1 in the cycle after the tenth consecutive tick at which `rx_line` was sampled high, and stays 1 while further samples stay high.
- R10: A tick at which `rx_line` is sampled low clears `rx_idle` in the next cycle and restarts the count of high samples.
- R11: After reset, `rx_idle` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | Single-cycle pulse, one per bit period |
| flow_en | input | 1 | 1 = clear-to-send may halt the transmitter at character boundaries |
| cts | input | 1 | Clear to send, 1 = clear |
| s_valid | input | 1 | Input byte is valid |
| s_data | input | DATA_BITS (8) | Input byte |
| s_ready | output | 1 | Byte is taken this cycle if `s_valid` is high |
| tx_line | output | 1 | Serial transmit line |
| rx_line | input | 1 | Receive line, already synchronous to `clk` |
| rx_idle | output | 1 | Receive line has been high for a full character time |

## Verification
The assertions take four things for granted:
- `baud_tick` is a single-cycle pulse.
- `rx_line` is already synchronous to `clk`.
- `s_data` holds steady while `s_valid` is high.
- `cts` matters only where a tick samples it.

The stimulus keeps to these limits as follows. It drives every input one time unit after a rising edge or on a falling edge. It fires a tick every fourth clock. It changes `cts` only just after a tick has put a known frame position on the line, so that each negation lands in a chosen bit position from 0 to 9.

// File: rtl/async_flow_tx_pkg.sv
package async_flow_tx_pkg;

    // Engine states: idle line, data character, halted idle character
    typedef enum logic [1:0] {
        TX_WAIT = 2'd0,
        TX_SEND = 2'd1,
        TX_HOLD = 2'd2
    } tx_state_e;

endpackage

// File: rtl/async_flow_tx_engine.sv
module async_flow_tx_engine
    import async_flow_tx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int MID_BIT   = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 baud_tick,
    input  logic                 flow_en,
    input  logic                 cts,
    input  logic                 s_valid,
    input  logic [DATA_BITS-1:0] s_data,
    output logic                 s_ready,
    output logic                 tx_line
);

    localparam int FRAME_BITS = DATA_BITS + 2;
    localparam int IW         = $clog2(FRAME_BITS);

    tx_state_e             st_q, st_d;
    logic [IW-1:0]         idx_q;
    logic [DATA_BITS-1:0]  sh_q;
    logic                  line_q;
    logic                  early_q;

    logic go_ok, last, halt_now, rdy, take;

    // Next-state and handshake decision
    always_comb begin
        go_ok    = cts | ~flow_en;
        last     = (idx_q == IW'(FRAME_BITS - 1));
        halt_now = flow_en & early_q;
        rdy      = 1'b0;
        st_d     = st_q;
        if (baud_tick) begin
            unique case (st_q)
                TX_WAIT: rdy = go_ok;
                TX_SEND: rdy = last & ~halt_now;
                TX_HOLD: rdy = last & go_ok;
                default: rdy = 1'b0;
            endcase
        end
        take = rdy & s_valid;
        if (take) begin
            st_d = TX_SEND;                              // launch, chain, resume
        end else if (baud_tick && last) begin
            if (st_q == TX_SEND)
                st_d = halt_now ? TX_HOLD : TX_WAIT;     // park or finish
            else if (st_q == TX_HOLD)
                st_d = go_ok ? TX_WAIT : TX_HOLD;        // release or repeat
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TX_WAIT;
        else        st_q <= st_d;
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q  <= 1'b1;
            idx_q   <= '0;
            sh_q    <= '0;
            early_q <= 1'b0;
        end else if (baud_tick) begin
            if (take) begin
                sh_q    <= s_data;
                line_q  <= 1'b0;
                idx_q   <= '0;
                early_q <= 1'b0;
            end else if (last || st_q == TX_WAIT) begin
                line_q  <= 1'b1;
                idx_q   <= '0;
                early_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
                if (st_q == TX_SEND) begin
                    if (idx_q < IW'(DATA_BITS)) begin
                        line_q <= sh_q[0];
                        sh_q   <= sh_q >> 1;
                    end else begin
                        line_q <= 1'b1;
                    end
                    if (flow_en && !cts && idx_q <= IW'(MID_BIT))
                        early_q <= 1'b1;
                end else begin
                    line_q <= 1'b1;
                end
            end
        end
    end

    assign s_ready = rdy;
    assign tx_line = line_q;

    // R1: the line moves only after a tick
    a_r1_line_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(line_q));

    // R3: an accepted byte is followed by its start bit
    a_r3_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && rdy) |=> !line_q);

    // R7: the halted engine keeps the line high
    a_r7_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TX_HOLD) |-> line_q);

endmodule

// File: rtl/async_flow_rx_idle.sv
module async_flow_rx_idle #(
    parameter int FRAME_BITS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic baud_tick,
    input  logic rx_line,
    output logic rx_idle
);

    localparam int CW = $clog2(FRAME_BITS + 1);

    logic [CW-1:0] cnt_q;
    logic          flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else if (baud_tick) begin
            if (!rx_line) begin
                cnt_q  <= '0;
                flag_q <= 1'b0;
            end else if (cnt_q != CW'(FRAME_BITS)) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CW'(FRAME_BITS - 1))
                    flag_q <= 1'b1;
            end
        end
    end

    assign rx_idle = flag_q;

    // R10: a low sample clears the flag
    a_r10_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_tick && !rx_line) |=> !flag_q);

    // R9: the flag only rises after a high sample
    a_r9_rise_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(rx_line && baud_tick));

endmodule

// File: rtl/async_flow_tx.sv
module async_flow_tx #(
    parameter int DATA_BITS = 8,
    parameter int MID_BIT   = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 baud_tick,
    input  logic                 flow_en,
    input  logic                 cts,
    input  logic                 s_valid,
    input  logic [DATA_BITS-1:0] s_data,
    output logic                 s_ready,
    output logic                 tx_line,
    input  logic                 rx_line,
    output logic                 rx_idle
);

    localparam int FRAME_BITS = DATA_BITS + 2;

    async_flow_tx_engine #(
        .DATA_BITS (DATA_BITS),
        .MID_BIT   (MID_BIT)
    ) engine_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .flow_en   (flow_en),
        .cts       (cts),
        .s_valid   (s_valid),
        .s_data    (s_data),
        .s_ready   (s_ready),
        .tx_line   (tx_line)
    );

    async_flow_rx_idle #(
        .FRAME_BITS (FRAME_BITS)
    ) idle_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .rx_line   (rx_line),
        .rx_idle   (rx_idle)
    );

endmodule

// File: tb/async_flow_tx_tb_top.sv
module async_flow_tx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       flow_en = 1'b0;
    logic       cts = 1'b1;
    logic       s_valid = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic       rx_line = 1'b1;
    logic       s_ready, tx_line, rx_idle;

    int nchk = 0;
    int nerr = 0;

    async_flow_tx dut_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .flow_en(flow_en),
        .cts(cts), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .tx_line(tx_line), .rx_line(rx_line), .rx_idle(rx_idle)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    // Tick generator: one pulse every TICK_DIV clocks
    initial begin
        int c;
        c = 0;
        forever begin
            @(negedge clk);
            c = (c + 1) % TICK_DIV;
            baud_tick = (c == 0);
        end
    end

    // Byte source
    logic [7:0] src_q[$];
    int sent_n = 0;
    initial begin
        forever begin
            @(posedge clk);
            if (rst_n && s_valid && s_ready) begin
                if (!baud_tick) chk(1'b0, "R3 accept without tick", 0, 1);
                sent_n++;
            end
            @(negedge clk);
            s_valid = (sent_n < src_q.size());
            s_data  = s_valid ? src_q[sent_n] : 8'h00;
        end
    end

    // Line decoder, one sample per bit period
    int nbits = 0, dpos = 0, fpos = -1, frames_started = 0, stop_err = 0;
    logic [7:0] sh = 8'h00;
    logic [7:0] got_q[$];
    int start_q[$];
    initial begin
        forever begin
            @(posedge clk);
            if (rst_n && baud_tick) begin
                #1;
                if (dpos == 0) begin
                    if (!tx_line) begin
                        dpos = 1; fpos = 0; frames_started++;
                        start_q.push_back(nbits);
                    end
                end else if (dpos <= 8) begin
                    sh = {tx_line, sh[7:1]};
                    fpos = dpos; dpos++;
                end else begin
                    fpos = 9;
                    if (!tx_line) stop_err++;
                    got_q.push_back(sh);
                    dpos = 0;
                end
                nbits++;
            end
        end
    end

    task automatic tick_wait();
        @(posedge clk);
        while (!baud_tick) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        src_q.delete(); sent_n = 0; s_valid = 1'b0;
        got_q.delete(); start_q.delete();
        nbits = 0; dpos = 0; fpos = -1; frames_started = 0; stop_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_rx(input int n, input int limit);
        for (int i = 0; i < limit && got_q.size() < n; i++) tick_wait();
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        // Reset state
        repeat (3) @(posedge clk);
        #1;
        chk(tx_line == 1'b1, "R2 reset line", tx_line, 1);
        chk(rx_idle == 1'b0, "R11 reset idle flag", rx_idle, 0);
        do_reset();
        repeat (8) @(posedge clk);
        #1;
        chk(tx_line == 1'b1, "R2 idle line", tx_line, 1);

        // R1/R3: all byte values, flow control off, back to back
        flow_en = 1'b0; cts = 1'b1;
        for (int v = 0; v < 256; v++) src_q.push_back(8'(v));
        wait_rx(256, 3000);
        chk(got_q.size() == 256, "R1 frame count", got_q.size(), 256);
        for (int v = 0; v < 256 && v < got_q.size(); v++)
            chk(got_q[v] == 8'(v), "R1 data bits", got_q[v], v);
        chk(stop_err == 0, "R1 stop bits", stop_err, 0);
        for (int v = 1; v < start_q.size(); v++)
            chk(start_q[v] - start_q[v-1] == 10, "R3 frame spacing",
                start_q[v] - start_q[v-1], 10);
        tick_wait();
        chk(tx_line == 1'b1, "R2 line after stream", tx_line, 1);

        // R4: cts low is ignored with flow control off
        do_reset();
        flow_en = 1'b0; cts = 1'b0;
        for (int v = 0; v < 12; v++) src_q.push_back(8'(v * 37 + 5));
        wait_rx(12, 400);
        chk(got_q.size() == 12, "R4 frames sent", got_q.size(), 12);
        for (int v = 0; v < 12 && v < got_q.size(); v++)
            chk(got_q[v] == 8'(v * 37 + 5), "R4 data", got_q[v], (v * 37 + 5) % 256);
        for (int v = 1; v < start_q.size(); v++)
            chk(start_q[v] - start_q[v-1] == 10, "R4 no stall",
                start_q[v] - start_q[v-1], 10);

        // R5/R6/R7/R8: negation at each bit position of the second frame
        for (int p = 0; p < 10; p++) begin
            int fs, a0, exp_extra;
            do_reset();
            flow_en = 1'b1; cts = 1'b1;
            for (int v = 0; v < 6; v++) src_q.push_back(8'(p * 16 + v + 1));
            wait (frames_started == 2 && fpos == p);
            cts = 1'b0;
            fs = frames_started;
            a0 = sent_n;
            exp_extra = (p > 5) ? 1 : 0;
            repeat (40) tick_wait();
            if (p > 5)
                chk(frames_started - fs == exp_extra, "R6 one more frame",
                    frames_started - fs, exp_extra);
            else
                chk(frames_started - fs == exp_extra, "R5 stop after current",
                    frames_started - fs, exp_extra);
            chk(sent_n - a0 == exp_extra, "R7 no accept while halted",
                sent_n - a0, exp_extra);
            chk(tx_line == 1'b1, "R7 line high while halted", tx_line, 1);
            cts = 1'b1;
            wait_rx(6, 120);
            chk(got_q.size() == 6, "R8 all bytes after resume", got_q.size(), 6);
            for (int v = 0; v < 6 && v < got_q.size(); v++)
                chk(got_q[v] == 8'(p * 16 + v + 1), "R8 order after resume",
                    got_q[v], p * 16 + v + 1);
            chk(stop_err == 0, "R1 stop bits under flow control", stop_err, 0);
        end

        // R9/R10: receive-idle detector, high runs of 1..12 samples
        for (int L = 1; L <= 12; L++) begin
            rx_line = 1'b0;
            tick_wait();
            chk(rx_idle == 1'b0, "R10 low sample clears", rx_idle, 0);
            rx_line = 1'b1;
            for (int k = 1; k <= L; k++) begin
                tick_wait();
                chk(rx_idle == (k >= 10), "R9 idle after full character",
                    rx_idle, (k >= 10) ? 1 : 0);
            end
        end
        rx_line = 1'b0;
        tick_wait();
        chk(rx_idle == 1'b0, "R10 clear after long run", rx_idle, 0);
        rx_line = 1'b1;
        for (int k = 1; k <= 9; k++) tick_wait();
        chk(rx_idle == 1'b0, "R10 count restarted", rx_idle, 0);

        finish_run();
    end

endmodule